// File: doc/BRIEF.md
# Configurable-Width Prescaled Timer

This block is a timer/counter that runs either as an 8-bit counter or, when a width bit is set, as one 16-bit counter. It offers two counting sequences: a free-running mode that wraps at the all-ones value and pulses an overflow output, and a clear-on-compare mode that restarts from zero once the count has reached a programmable TOP value and pulses a match output. In 16-bit mode the two 8-bit compare bytes together form a single 16-bit TOP.

The counter steps only on enable ticks from a free-running prescaler. A three-bit clock-select field picks the tick rate: every cycle, one of four divided rates, or no ticks at all. Software reaches the control byte, the two counter bytes and the two compare bytes through an 8-bit register port. Each 16-bit value moves one byte at a time through holding latches, so a write or read of a 16-bit value is seen as one consistent value.

Top module: `cfg_timer`

## Requirements
- R1: After reset the control byte reads 0x00, the counter reads 0, and `match_o` and `ovf_o` are low. The timer is stopped in 8-bit free-running mode.
- R2: Address 0 is the control byte, and all eight bits are read/write. Bit 7 selects 16-bit width, bit 3 selects clear-on-compare mode, and bits [2:0] are the clock select. Bits [6:4] are stored and read back.
- R3: The counter advances by one only on prescaler ticks. The prescaler is a free-running divider started by reset. Clock select 001 ticks every cycle, 010 every 8th cycle, 011 every 64th, 100 every 256th and 101 every 1024th. Codes 000, 110 and 111 give no ticks and the counter holds.
- R4: In 8-bit free-running mode, a tick at count 0xFF sets the count to 0x00. `ovf_o` is high for exactly the one cycle after that clock edge.
- R5: In 16-bit free-running mode the count wraps from 0xFFFF to 0 with the same one-cycle `ovf_o` pulse, and it passes from 0x00FF to 0x0100 without an overflow pulse.
- R6: In clear-on-compare mode, a tick while the count equals TOP sets the count to 0 and pulses `match_o` for one cycle. The period is therefore TOP+1 ticks. `ovf_o` never pulses in this mode, and `match_o` never pulses in free-running mode.
- R7: In 8-bit mode TOP is the low compare byte (address 3), and the high compare byte (address 4) has no effect. In 16-bit mode TOP is {address 4, address 3}.
- R8: In 16-bit mode, a write to a high byte (address 2 for the count, address 4 for the compare) goes only into a holding latch. The following write to the matching low byte (address 1 or 3) updates all 16 bits at once. Before that, the 16-bit register reads back unchanged.
- R9: A read of address 1 returns the count's low byte and captures its high byte. A later read of address 2 returns the captured byte, even if the count has changed since.
- R10: In 8-bit mode, a write to address 1 loads the count with {0x00, data}, and writes to addresses 3 and 4 go straight into their compare bytes. A count write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (captures the count high byte on an address 1 read) |
| addr_i | input | 3 | Register address: 0 control, 1/2 count low/high, 3/4 compare low/high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| match_o | output | 1 | One-cycle compare-match pulse (clear-on-compare mode) |
| ovf_o | output | 1 | One-cycle overflow pulse (free-running mode) |

## Verification
A table sweeps all eight clock-select codes. Each code runs for a whole multiple of its divisor, which tells the divided rates apart from each other and from the stop codes whatever the prescaler phase. Directed runs start the count just below the wrap point in each width. These separate 8-bit from 16-bit wrap detection and show that crossing the byte boundary in 16-bit mode is not an overflow. Clear-on-compare runs use an 8-bit TOP with a distracting high compare byte and then a 16-bit TOP, checking both the pulse position and its period. Byte-access sequences show that a high-byte write stays invisible until its low byte is written, and that a captured high byte outlives a later change to the count.

// File: rtl/cfg_timer_pkg.sv
package cfg_timer_pkg;
  parameter int unsigned DW = 8;
  parameter int unsigned CW = 2 * DW;
  parameter int unsigned PW = 10;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_CMP_LO = 3'd3,
    A_CMP_HI = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic       wide;
    logic [2:0] spare;
    logic       ctc;
    logic [2:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/cfg_timer_presc.sv
module cfg_timer_presc
  import cfg_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] clk_sel_i,
  output logic       tick_o
);
  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (clk_sel_i)
      3'd1:    tick_o = 1'b1;
      3'd2:    tick_o = &div_q[2:0];
      3'd3:    tick_o = &div_q[5:0];
      3'd4:    tick_o = &div_q[7:0];
      3'd5:    tick_o = &div_q[9:0];
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_timer_core.sv
module cfg_timer_core
  import cfg_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wide_i,
  input  logic          ctc_i,
  input  logic [CW-1:0] top_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          match_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q, cnt_inc;
  logic          at_top, at_max;

  assign at_top  = wide_i ? (cnt_q == top_i) : (cnt_q[DW-1:0] == top_i[DW-1:0]);
  assign at_max  = wide_i ? (&cnt_q) : (&cnt_q[DW-1:0]);
  assign cnt_inc = wide_i ? cnt_q + 1'b1 : {{DW{1'b0}}, cnt_q[DW-1:0] + 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      match_o <= 1'b0;
      ovf_o   <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (tick_i) begin
        if (ctc_i && at_top) begin
          cnt_q   <= '0;
          match_o <= 1'b1;
        end else if (at_max) begin
          cnt_q <= '0;
          ovf_o <= !ctc_i;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  assign cnt_o = cnt_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R3
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt_q == '0)); // R4
  AST_OVF_FREE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !$past(ctc_i)); // R6
  AST_MATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (cnt_q == '0) && $past(ctc_i)); // R6
endmodule

// File: rtl/cfg_timer_regs.sv
module cfg_timer_regs
  import cfg_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [CW-1:0] cnt_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] top_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] cmp_lo_q, cmp_hi_q, hold_wr_q, hold_rd_q;
  logic          wide;

  assign wide = ctrl_q.wide;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      cmp_lo_q  <= '0;
      cmp_hi_q  <= '0;
      hold_wr_q <= '0;
      hold_rd_q <= '0;
    end else begin
      if (wr_en_i) begin
        unique case (addr_i)
          A_CTRL:   ctrl_q <= ctrl_t'(wdata_i);
          A_CNT_HI: hold_wr_q <= wdata_i;
          A_CMP_HI: begin
            if (wide) hold_wr_q <= wdata_i;
            else      cmp_hi_q  <= wdata_i;
          end
          A_CMP_LO: begin
            cmp_lo_q <= wdata_i;
            if (wide) cmp_hi_q <= hold_wr_q;
          end
          default: ;
        endcase
      end
      if (rd_en_i && addr_i == A_CNT_LO) hold_rd_q <= cnt_i[CW-1:DW];
    end
  end

  assign load_o     = wr_en_i && (addr_i == A_CNT_LO);
  assign load_val_o = wide ? {hold_wr_q, wdata_i} : {{DW{1'b0}}, wdata_i};
  assign top_o      = wide ? {cmp_hi_q, cmp_lo_q} : {{DW{1'b0}}, cmp_lo_q};
  assign ctrl_o     = ctrl_q;

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rdata_o = ctrl_q;
      A_CNT_LO: rdata_o = cnt_i[DW-1:0];
      A_CNT_HI: rdata_o = hold_rd_q;
      A_CMP_LO: rdata_o = cmp_lo_q;
      A_CMP_HI: rdata_o = cmp_hi_q;
      default:  rdata_o = '0;
    endcase
  end

  AST_CMP_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wide && addr_i == A_CMP_HI) |=> $stable({cmp_hi_q, cmp_lo_q})); // R8
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == A_CNT_LO) |=> $stable(hold_rd_q)); // R9
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
  import cfg_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          match_o,
  output logic          ovf_o
);
  ctrl_t         ctrl;
  logic [CW-1:0] top, cnt, load_val;
  logic          load, tick;

  cfg_timer_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .ctrl_o(ctrl), .top_o(top), .load_o(load), .load_val_o(load_val)
  );

  cfg_timer_presc u_presc (
    .clk_i, .rst_ni, .clk_sel_i(ctrl.clk_sel), .tick_o(tick)
  );

  cfg_timer_core u_core (
    .clk_i, .rst_ni, .tick_i(tick), .wide_i(ctrl.wide), .ctc_i(ctrl.ctc),
    .top_i(top), .load_i(load), .load_val_i(load_val),
    .cnt_o(cnt), .match_o, .ovf_o
  );
endmodule

// File: tb/cfg_timer_tb_top.sv
module cfg_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int NROW = 8;
  localparam logic [2:0]  T_CS  [NROW] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam int          T_N   [NROW] = '{40, 40, 64, 256, 1024, 4096, 100, 100};
  localparam logic [15:0] T_EXP [NROW] = '{16'd0, 16'd40, 16'd8, 16'd4, 16'd4, 16'd4, 16'd0, 16'd0};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       match_o, ovf_o;

  int checks = 0, failures = 0;
  bit done = 0;

  cfg_timer dut_i (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_en_i = 1; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo); rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic wr_cnt16(logic [15:0] v);
    wr(3'd2, v[15:8]); wr(3'd1, v[7:0]);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    int nm, no;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 match", match_o, 0);
    chk("R1 ovf", ovf_o, 0);
    rd(3'd0, b); chk("R1 ctrl", b, 8'h00);
    rd16(v); chk("R1 count", v, 16'h0000);

    // R3 clock-select table
    for (int i = 0; i < NROW; i++) begin
      wr(3'd0, 8'h80);
      wr_cnt16(16'h0000);
      wr(3'd0, {5'b10000, T_CS[i]});
      repeat (T_N[i] - 1) @(negedge clk_i);
      wr(3'd0, 8'h80);
      rd16(v); chk($sformatf("R3 cs=%0d", T_CS[i]), v, T_EXP[i]);
    end

    // R2 control byte read/write
    wr(3'd0, 8'h70); rd(3'd0, b); chk("R2 spare bits", b, 8'h70);
    wr(3'd0, 8'h00);

    // R4 8-bit wrap, R10 8-bit count load
    wr(3'd1, 8'hFE);
    rd(3'd1, b); chk("R10 load low", b, 8'hFE);
    wr(3'd0, 8'h01);
    @(negedge clk_i); chk("R4 ovf before wrap", ovf_o, 0);
    @(negedge clk_i); chk("R4 ovf pulse", ovf_o, 1);
    wr(3'd0, 8'h00);
    chk("R4 ovf one cycle", ovf_o, 0);
    rd16(v); chk("R4 count after wrap", v, 16'h0001);

    // R5 16-bit wrap
    wr(3'd0, 8'h80);
    wr_cnt16(16'hFFFE);
    rd16(v); chk("R8 count load16", v, 16'hFFFE);
    wr(3'd0, 8'h81);
    @(negedge clk_i); chk("R5 ovf before wrap", ovf_o, 0);
    @(negedge clk_i); chk("R5 ovf pulse", ovf_o, 1);
    wr(3'd0, 8'h80);
    rd16(v); chk("R5 count after wrap", v, 16'h0001);

    // R5 byte boundary without overflow
    wr_cnt16(16'h00FE);
    wr(3'd0, 8'h81);
    no = 0;
    for (int k = 0; k < 4; k++) begin @(negedge clk_i); no += ovf_o; end
    wr(3'd0, 8'h80);
    chk("R5 no ovf at 0xFF->0x100", no, 0);
    rd16(v); chk("R5 count crosses byte", v, 16'h0103);

    // R6/R7 8-bit clear-on-compare with distracting high byte
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h05);
    wr(3'd4, 8'h07);
    rd(3'd4, b); chk("R10 cmp hi direct", b, 8'h07);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h09);
    nm = 0; no = 0;
    for (int k = 0; k < 18; k++) begin
      @(negedge clk_i); nm += match_o; no += ovf_o;
    end
    wr(3'd0, 8'h00);
    chk("R6 R7 match count 8b", nm, 3);
    chk("R6 no ovf in ctc", no, 0);
    rd(3'd1, b); chk("R6 count after stop", b, 8'h01);

    // R8 atomic compare write, R7 16-bit TOP
    wr(3'd0, 8'h80);
    wr(3'd4, 8'h01);
    rd(3'd4, b); chk("R8 cmp hi held", b, 8'h07);
    rd(3'd3, b); chk("R8 cmp lo held", b, 8'h05);
    wr(3'd3, 8'h02);
    rd(3'd4, b); chk("R8 cmp hi commit", b, 8'h01);
    rd(3'd3, b); chk("R8 cmp lo commit", b, 8'h02);
    wr_cnt16(16'h00FF);
    wr(3'd0, 8'h89);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk($sformatf("R7 match16 step%0d", k), match_o, (k == 3) ? 1 : 0);
    end
    wr(3'd0, 8'h80);
    rd16(v); chk("R6 count16 after clear", v, 16'h0001);

    // R9 read capture
    wr_cnt16(16'h1234);
    rd(3'd1, b); chk("R9 low byte", b, 8'h34);
    wr_cnt16(16'hAB00);
    rd(3'd2, b); chk("R9 captured high", b, 8'h12);
    rd16(v); chk("R9 fresh read", v, 16'hAB00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule